// File: doc/BRIEF.md
# Multi-Link Frame Sync Generator

This block watches the frame-start (VSYNC) inputs of up to four camera links that share one pixel clock and returns a single frame-sync pulse to every sensor. A frame is the span from the first rising VSYNC edge among the participating links to the moment every participating link has shown its rising edge. The cycle that completes the set is the reference: it belongs to the slowest link, and the sync pulse is timed from it. A link participates when it is enabled and still alive. A link is alive while its VSYNC keeps arriving.

A signed cycle margin places the pulse after the reference edge, or before the next predicted one. The prediction uses the frame period measured between the last two reference edges. A 4-bit divider thins the pulses to one every N+1 frames. In each frame the block also measures the cycle skew between the earliest and latest rising edge. It raises a one-cycle error strobe and a sticky flag when the skew passes a programmable limit. An option holds an early pulse back until the last link of the current frame has been seen. All configuration inputs are static. The block also produces a merged and optionally inverted copy of the incoming VSYNC.

Top module: `mlink_fsync_gen`

## Requirements
- R1: After reset `fsync_o`, `vsync_o`, `skew_err_o` and `skew_sticky_o` are low and every bit of `link_alive_o` is high.
- R2: With `margin_neg_i` low and margin m, `fsync_o` rises 1+m cycles after the cycle in which the last-arriving participating link shows its rising VSYNC edge.
- R3: Each sync pulse stays high for exactly 8 cycles. A trigger that arrives while a pulse is high is dropped and does not extend or restart it.
- R4: With divider value N, the first frame after reset produces a pulse, then every (N+1)-th frame does. N=0 gives a pulse for every frame.
- R5: With `margin_neg_i` high, no pulse follows the first frame after reset. For later frames, P is the number of cycles between the last two reference edges, and `fsync_o` rises 1+P−m cycles after the reference edge. It rises one cycle after the reference edge when P ≤ m.
- R6: The skew is the cycle distance from the first to the last rising edge of a frame. When it exceeds a nonzero `skew_thr_i`, `skew_err_o` is high for the single cycle after the reference edge and `skew_sticky_o` stays high until reset. A skew equal to the threshold is not an error.
- R7: A threshold of zero never produces an error, whatever the skew.
- R8: With `wait_all_i` high, a negative-margin pulse that falls due while a frame is only partly seen waits. It then rises one cycle after that frame's reference edge. With `wait_all_i` low it rises on schedule.
- R9: With nonzero `timeout_i`, a link that shows no rising edge for about `timeout_i` cycles drops its `link_alive_o` bit and no longer holds back the reference. Its next rising edge restores the bit.
- R10: A link whose `link_en_i` bit is low has no effect on frame timing or skew.
- R11: `vsync_o` is the OR of the VSYNC levels of the participating links, one cycle late, inverted when `vs_inv_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | NLINK | VSYNC level per link |
| link_en_i | input | NLINK | Link enable mask |
| div_i | input | DW | Frame divider (pulse every div_i+1 frames) |
| margin_i | input | CW | Sync offset magnitude in cycles |
| margin_neg_i | input | 1 | High: place the pulse before the predicted edge |
| skew_thr_i | input | CW | Skew limit in cycles, zero disables |
| wait_all_i | input | 1 | Hold early pulses until the frame is fully seen |
| vs_inv_i | input | 1 | Invert the forwarded VSYNC |
| timeout_i | input | TW | Link silence limit in cycles, zero disables |
| fsync_o | output | 1 | Frame-sync pulse |
| vsync_o | output | 1 | Merged, optionally inverted VSYNC |
| skew_err_o | output | 1 | One-cycle skew error strobe |
| skew_sticky_o | output | 1 | Sticky skew error |
| link_alive_o | output | NLINK | Liveness per link |

## Verification
Single frames are driven with different link offsets and enable masks. These show whether the reference follows the latest enabled edge rather than the first one or a disabled one, and whether a skew equal to, one above or below the threshold is judged correctly. Periodic runs separate the divider count, the predicted negative offset and its P ≤ m fallback. A pair of runs that differ only in the wait option shows the deferral. A fast frame rate exposes any retrigger of the pulse. Silencing one link and then restoring it shows that the reference moves to the remaining links and that liveness comes back.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_COUNT = 2'd1,
    SCH_HOLD  = 2'd2
  } sch_state_e;
endpackage

// File: rtl/fsg_link_track.sv
// Per-link rising-edge detector and liveness monitor.
module fsg_link_track #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vsync_i,
  input  logic [TW-1:0] timeout_i,
  output logic          rise_o,
  output logic          alive_o
);
  logic          vs_q;
  logic [TW-1:0] quiet_q;

  assign rise_o = vsync_i & ~vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q    <= 1'b0;
      quiet_q <= '0;
      alive_o <= 1'b1;
    end else begin
      vs_q <= vsync_i;
      if (rise_o) begin
        quiet_q <= '0;
        alive_o <= 1'b1;
      end else begin
        if (quiet_q != '1) quiet_q <= quiet_q + 1'b1;
        if (timeout_i != '0 && quiet_q >= timeout_i - 1'b1) alive_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsg_frame_win.sv
// Frame window: tracks which links have shown their edge, finds the
// reference (last) edge, measures skew and frame period.
module fsg_frame_win #(
  parameter int NL = 4,
  parameter int CW = 13,
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] rise_i,
  input  logic [NL-1:0] part_i,
  input  logic [CW-1:0] thr_i,
  output logic          close_o,
  output logic          open_o,
  output logic [PW-1:0] period_o,
  output logic          per_valid_o,
  output logic          err_o,
  output logic          sticky_o
);
  localparam int SW = CW + 1;

  logic [NL-1:0] seen_q, seen_nxt, hit;
  logic          open_q, act, over;
  logic [SW-1:0] skew_q, skew_now;
  logic [PW-1:0] per_q;

  assign hit      = rise_i & part_i;
  assign act      = open_q | (|hit);
  assign seen_nxt = (open_q ? seen_q : '0) | hit;
  assign close_o  = act && (part_i != '0) && ((part_i & ~seen_nxt) == '0);
  assign skew_now = open_q ? skew_q : '0;
  assign over     = (thr_i != '0) && (skew_now > {1'b0, thr_i});
  assign period_o = (per_q == '1) ? per_q : per_q + 1'b1;
  assign open_o   = open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q      <= '0;
      open_q      <= 1'b0;
      skew_q      <= '0;
      per_q       <= '0;
      per_valid_o <= 1'b0;
      err_o       <= 1'b0;
      sticky_o    <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (per_q != '1) per_q <= per_q + 1'b1;
      if (close_o) begin
        seen_q      <= '0;
        open_q      <= 1'b0;
        skew_q      <= '0;
        per_q       <= '0;
        per_valid_o <= 1'b1;
        err_o       <= over;
        if (over) sticky_o <= 1'b1;
      end else if (act) begin
        open_q <= 1'b1;
        seen_q <= seen_nxt;
        if (!open_q)           skew_q <= {{(SW-1){1'b0}}, 1'b1};
        else if (skew_q != '1) skew_q <= skew_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsg_fire_sched.sv
// Frame divider, signed-margin scheduler and fixed-length pulse shaper.
module fsg_fire_sched
  import fsg_pkg::*;
#(
  parameter int CW    = 13,
  parameter int PW    = 20,
  parameter int DW    = 4,
  parameter int PULSE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          close_i,
  input  logic          win_open_i,
  input  logic [PW-1:0] period_i,
  input  logic          per_valid_i,
  input  logic [DW-1:0] div_i,
  input  logic [CW-1:0] margin_i,
  input  logic          neg_i,
  input  logic          wait_all_i,
  output logic          fsync_o
);
  localparam int LW = (PULSE > 2) ? $clog2(PULSE) : 1;

  sch_state_e    state_q;
  logic [PW-1:0] cnt_q, dly, margin_x;
  logic [DW-1:0] div_q;
  logic [LW-1:0] len_q;
  logic          trig, arm, block, due, fire_old, imm, fire;

  assign margin_x = {{(PW-CW){1'b0}}, margin_i};
  assign trig     = close_i && (div_q == '0);

  always_comb begin
    if (!neg_i) begin
      arm = trig;
      dly = margin_x;
    end else begin
      arm = trig && per_valid_i;
      dly = (period_i > margin_x) ? period_i - margin_x : '0;
    end
  end

  assign block    = wait_all_i && win_open_i && !close_i;
  assign due      = (state_q == SCH_COUNT) && (cnt_q == {{(PW-1){1'b0}}, 1'b1});
  assign fire_old = ((state_q == SCH_HOLD) || due) && !block;
  assign imm      = arm && (dly == '0);
  assign fire     = fire_old | imm;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SCH_IDLE;
      cnt_q   <= '0;
      div_q   <= '0;
    end else begin
      if (close_i) div_q <= (div_q == '0) ? div_i : div_q - 1'b1;
      if (arm && dly != '0) begin
        state_q <= SCH_COUNT;
        cnt_q   <= dly;
      end else if (fire_old) begin
        state_q <= SCH_IDLE;
      end else if (due && block) begin
        state_q <= SCH_HOLD;
      end else if (state_q == SCH_COUNT) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsync_o <= 1'b0;
      len_q   <= '0;
    end else if (fire && !fsync_o) begin
      fsync_o <= 1'b1;
      len_q   <= LW'(PULSE - 1);
    end else if (fsync_o) begin
      if (len_q == '0) fsync_o <= 1'b0;
      else             len_q   <= len_q - 1'b1;
    end
  end
endmodule

// File: rtl/mlink_fsync_gen.sv
module mlink_fsync_gen
  import fsg_pkg::*;
#(
  parameter int NLINK     = 4,
  parameter int CW        = 13,
  parameter int DW        = 4,
  parameter int PW        = 20,
  parameter int TW        = 16,
  parameter int PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINK-1:0] vsync_i,
  input  logic [NLINK-1:0] link_en_i,
  input  logic [DW-1:0]    div_i,
  input  logic [CW-1:0]    margin_i,
  input  logic             margin_neg_i,
  input  logic [CW-1:0]    skew_thr_i,
  input  logic             wait_all_i,
  input  logic             vs_inv_i,
  input  logic [TW-1:0]    timeout_i,
  output logic             fsync_o,
  output logic             vsync_o,
  output logic             skew_err_o,
  output logic             skew_sticky_o,
  output logic [NLINK-1:0] link_alive_o
);
  logic [NLINK-1:0] rise_w, part_w;
  logic [PW-1:0]    period_w;
  logic             close_w, open_w, per_valid_w;

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    fsg_link_track #(.TW(TW)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .vsync_i   (vsync_i[g]),
      .timeout_i (timeout_i),
      .rise_o    (rise_w[g]),
      .alive_o   (link_alive_o[g])
    );
  end

  assign part_w = link_en_i & link_alive_o;

  fsg_frame_win #(.NL(NLINK), .CW(CW), .PW(PW)) u_win (
    .clk         (clk),
    .rst         (rst),
    .rise_i      (rise_w),
    .part_i      (part_w),
    .thr_i       (skew_thr_i),
    .close_o     (close_w),
    .open_o      (open_w),
    .period_o    (period_w),
    .per_valid_o (per_valid_w),
    .err_o       (skew_err_o),
    .sticky_o    (skew_sticky_o)
  );

  fsg_fire_sched #(.CW(CW), .PW(PW), .DW(DW), .PULSE(PULSE_LEN)) u_sch (
    .clk         (clk),
    .rst         (rst),
    .close_i     (close_w),
    .win_open_i  (open_w),
    .period_i    (period_w),
    .per_valid_i (per_valid_w),
    .div_i       (div_i),
    .margin_i    (margin_i),
    .neg_i       (margin_neg_i),
    .wait_all_i  (wait_all_i),
    .fsync_o     (fsync_o)
  );

  always_ff @(posedge clk) begin
    if (rst) vsync_o <= 1'b0;
    else     vsync_o <= (|(vsync_i & part_w)) ^ vs_inv_i;
  end
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
  parameter int NLINK     = 4,
  parameter int CW        = 13,
  parameter int PULSE_LEN = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             fsync_o,
  input logic             skew_err_o,
  input logic             skew_sticky_o,
  input logic             close_w,
  input logic [CW-1:0]    skew_thr_i,
  input logic [NLINK-1:0] vsync_i,
  input logic [NLINK-1:0] link_alive_o
);
  logic [15:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst)          hi_q <= '0;
    else if (fsync_o) hi_q <= (hi_q == '1) ? hi_q : hi_q + 1'b1;
    else              hi_q <= '0;
  end

  // R3
  pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
    fsync_o |-> (hi_q < 16'(PULSE_LEN)));

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fsync_o) |-> ($past(hi_q) == 16'(PULSE_LEN - 1)));

  // R6
  err_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
    skew_err_o |-> $past(close_w));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    skew_err_o |=> !skew_err_o);

  // R6
  err_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    skew_err_o |-> skew_sticky_o);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(skew_sticky_o));

  // R7
  thr_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(skew_thr_i) == '0) |-> !skew_err_o);

  for (genvar g = 0; g < NLINK; g++) begin : g_alive
    // R9
    alive_return_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(link_alive_o[g]) |-> $past(vsync_i[g]));
  end
endmodule

bind mlink_fsync_gen fsg_chk #(
  .NLINK(NLINK), .CW(CW), .PULSE_LEN(PULSE_LEN)
) u_fsg_chk (
  .clk           (clk),
  .rst           (rst),
  .fsync_o       (fsync_o),
  .skew_err_o    (skew_err_o),
  .skew_sticky_o (skew_sticky_o),
  .close_w       (close_w),
  .skew_thr_i    (skew_thr_i),
  .vsync_i       (vsync_i),
  .link_alive_o  (link_alive_o)
);

// File: tb/tb_mlink_fsync_gen.sv
`timescale 1ns/1ps
module tb_mlink_fsync_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  vsync_i = '0, link_en_i = 4'hF;
  logic [3:0]  div_i = '0;
  logic [12:0] margin_i = '0, skew_thr_i = '0;
  logic        margin_neg_i = 1'b0, wait_all_i = 1'b0, vs_inv_i = 1'b0;
  logic [15:0] timeout_i = '0;
  logic        fsync_o, vsync_o, skew_err_o, skew_sticky_o;
  logic [3:0]  link_alive_o;

  always #4 clk = ~clk;

  mlink_fsync_gen dut (
    .clk(clk), .rst(rst), .vsync_i(vsync_i), .link_en_i(link_en_i),
    .div_i(div_i), .margin_i(margin_i), .margin_neg_i(margin_neg_i),
    .skew_thr_i(skew_thr_i), .wait_all_i(wait_all_i), .vs_inv_i(vs_inv_i),
    .timeout_i(timeout_i), .fsync_o(fsync_o), .vsync_o(vsync_o),
    .skew_err_o(skew_err_o), .skew_sticky_o(skew_sticky_o),
    .link_alive_o(link_alive_o)
  );

  int nchk = 0, nfail = 0;
  int rt [16];
  int nrise, nerr, maxrun;

  typedef struct packed {
    logic [3:0]  en;
    logic [7:0]  o0, o1, o2, o3;
    logic [7:0]  m;
    logic [12:0] thr;
  } row_t;

  // R2 R6 R7 R10: single frames, expected rise = latest enabled offset + 1 + m
  localparam row_t ROWS [6] = '{
    '{4'hF, 8'd0,  8'd3,  8'd7, 8'd5,  8'd0, 13'd0},
    '{4'hF, 8'd2,  8'd2,  8'd2, 8'd2,  8'd5, 13'd1},
    '{4'h5, 8'd10, 8'd40, 8'd4, 8'd30, 8'd2, 13'd5},
    '{4'hF, 8'd5,  8'd1,  8'd9, 8'd20, 8'd3, 13'd19},
    '{4'hF, 8'd5,  8'd1,  8'd9, 8'd20, 8'd3, 13'd18},
    '{4'h8, 8'd0,  8'd0,  8'd0, 8'd6,  8'd0, 13'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    vsync_i = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int ncyc, input int period, input int o0, input int o1,
                     input int o2, input int o3, input logic [3:0] gen);
    int off [4];
    bit prev;
    int r;
    off[0] = o0; off[1] = o1; off[2] = o2; off[3] = o3;
    nrise = 0; nerr = 0; maxrun = 0; r = 0;
    prev = fsync_o;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (fsync_o) begin
        r++;
        if (!prev) begin
          if (nrise < 16) rt[nrise] = i;
          nrise++;
        end
      end else r = 0;
      if (r > maxrun) maxrun = r;
      prev = fsync_o;
      if (skew_err_o) nerr++;
      for (int l = 0; l < 4; l++)
        vsync_i[l] = gen[l] && ((i % period) >= off[l]) && ((i % period) < off[l] + 4);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    chk(!fsync_o && !vsync_o && !skew_err_o && !skew_sticky_o, "R1 outputs low",
        {fsync_o, vsync_o, skew_err_o, skew_sticky_o}, 0);
    chk(link_alive_o == 4'hF, "R1 alive", link_alive_o, 15);

    foreach (ROWS[k]) begin
      int offs [4];
      int mx, mn, exp_r;
      bit exp_e;
      offs[0] = ROWS[k].o0; offs[1] = ROWS[k].o1;
      offs[2] = ROWS[k].o2; offs[3] = ROWS[k].o3;
      mx = -1; mn = 1000;
      for (int l = 0; l < 4; l++)
        if (ROWS[k].en[l]) begin
          if (offs[l] > mx) mx = offs[l];
          if (offs[l] < mn) mn = offs[l];
        end
      exp_r = mx + 1 + int'(ROWS[k].m);
      exp_e = (ROWS[k].thr != 0) && ((mx - mn) > int'(ROWS[k].thr));
      link_en_i = ROWS[k].en; margin_i = 13'(ROWS[k].m); skew_thr_i = ROWS[k].thr;
      margin_neg_i = 0; div_i = 0; wait_all_i = 0; timeout_i = 0;
      do_reset();
      run(60, 60, offs[0], offs[1], offs[2], offs[3], 4'hF);
      // R2 R10
      chk(nrise == 1 && rt[0] == exp_r, "R2/R10 rise cycle", rt[0], exp_r);
      // R3
      chk(maxrun == 8, "R3 pulse length", maxrun, 8);
      // R6 R7
      chk((nerr == 1) == exp_e && (nerr <= 1), "R6/R7 strobe", nerr, int'(exp_e));
      chk(skew_sticky_o == exp_e, "R6 sticky", skew_sticky_o, int'(exp_e));
    end

    link_en_i = 4'hF; skew_thr_i = 0; margin_i = 0;

    // R4 divider 2: frames 0,3,6 of 9
    div_i = 2; do_reset();
    run(180, 20, 3, 3, 3, 3, 4'hF);
    chk(nrise == 3, "R4 pulse count", nrise, 3);
    chk(rt[0] == 4 && rt[1] == 64 && rt[2] == 124, "R4 pulse spacing", rt[1], 64);
    div_i = 0;

    // R3 retrigger: frames every 5 cycles
    do_reset();
    run(30, 5, 0, 0, 0, 0, 4'hF);
    chk(nrise == 3 && rt[1] == 11 && rt[2] == 21, "R3 no retrigger", rt[1], 11);
    chk(maxrun == 8, "R3 length under load", maxrun, 8);

    // R5 negative margin
    margin_neg_i = 1; margin_i = 6; do_reset();
    run(160, 50, 10, 10, 10, 10, 4'hF);
    chk(nrise == 2, "R5 none on first frame", nrise, 2);
    chk(rt[0] == 105 && rt[1] == 155, "R5 predicted rise", rt[0], 105);

    margin_i = 60; do_reset();
    run(120, 50, 10, 10, 10, 10, 4'hF);
    chk(nrise == 2 && rt[0] == 61, "R5 period not above margin", rt[0], 61);

    // R8 wait option off / on
    margin_i = 10; wait_all_i = 0; do_reset();
    run(200, 50, 10, 30, 30, 30, 4'hF);
    chk(nrise == 2 && rt[0] == 121 && rt[1] == 171, "R8 on schedule", rt[0], 121);
    wait_all_i = 1; do_reset();
    run(200, 50, 10, 30, 30, 30, 4'hF);
    chk(nrise == 2 && rt[0] == 131 && rt[1] == 181, "R8 deferred", rt[0], 131);
    wait_all_i = 0; margin_neg_i = 0; margin_i = 0;

    // R9 liveness
    timeout_i = 100; do_reset();
    run(100, 50, 5, 5, 5, 20, 4'hF);
    run(300, 50, 5, 5, 5, 20, 4'h7);
    chk(link_alive_o[3] == 1'b0, "R9 silent link dropped", link_alive_o[3], 0);
    chk(link_alive_o[2:0] == 3'b111, "R9 active links alive", link_alive_o[2:0], 7);
    chk(nrise >= 1 && nrise <= 16 && rt[nrise-1] == 256, "R9 reference moves", rt[nrise-1], 256);
    run(50, 50, 5, 5, 5, 20, 4'hF);
    chk(link_alive_o[3] == 1'b1, "R9 link restored", link_alive_o[3], 1);
    timeout_i = 0;

    // R11 forwarded vsync
    do_reset();
    vsync_i = 4'b0100;
    @(negedge clk);
    chk(vsync_o == 1'b1, "R11 merge", vsync_o, 1);
    vs_inv_i = 1;
    @(negedge clk);
    chk(vsync_o == 1'b0, "R11 invert", vsync_o, 0);
    vs_inv_i = 0; link_en_i = 4'b1011;
    @(negedge clk);
    chk(vsync_o == 1'b0, "R11 disabled link masked", vsync_o, 0);
    vsync_i = '0; link_en_i = 4'hF;

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule